// File: doc/BRIEF.md
# Segment Stream Packet Framer

The framer turns a gated sample flow into a stream of 64-bit words that describes itself. After a start request it sends one stream header once. For every segment after that it sends a packet header, the packed payload samples and a footer. Configuration inputs fill the static header fields. Timestamps are captured from a free-running integer-plus-fraction counter, once when the segment opens and once at each trigger event.

The output uses a valid/ready handshake. The sample input has a ready signal of its own. A stalled output blocks sample intake. A sample that is offered but not taken raises a flag for that cycle and is dropped.

The footer holds the same fields as the packet header. It also carries the segment length that was actually sent, counted in 64-bit payload words. A segment of variable length, or one cut short, can therefore be decoded later from the footer alone.

Top module: `seg_stream_framer`

## Requirements
- R1: While reset is low and right after it, `o_valid`, `smp_rdy` and `smp_ovf` are low.
- R2: `strm_go` starts the stream only once after reset, and any later pulse is ignored. The stream header is 36 words sent least significant first. Word 0 is the magic value. Word 1 holds the version in bits 7:0, the meta type 0 in bits 9:8, the sample rate in MSa/s in bits 47:32, the decimation exponent in bits 55:48, and bits 7:0 of the period in femtoseconds in bits 63:56. Word 2 holds period bits 63:8 in bits 55:0. Every other bit is zero.
- R3: A packet header is 18 words. Word 0 is the magic value. Word 1 holds the version in bits 7:0 and the meta type 1 in bits 9:8. The segment length field is zero: word 1 bits 63:32 and word 2 bits 31:0. The first-sample integer timestamp fills word 2 bits 63:32 and word 3 bits 31:0. Its 32-bit fraction fills word 3 bits 63:32. The trigger integer timestamp fills word 4, and its fraction fills word 5 bits 31:0. Every other bit is zero.
- R4: `seg_open` is accepted only while the framer waits between segments, and a pulse at any other time is ignored. The first-sample timestamp is the `ts_whole`/`ts_frac` value in the cycle the pulse is accepted.
- R5: The trigger timestamp of a segment is the timestamp captured at the latest `trig_evt` pulse at or before the cycle the segment opens. A pulse in that same cycle takes that cycle's value. Before any trigger the value is zero.
- R6: Accepted samples are packed five to a payload word. The k-th sample sits in bits 12k+11:12k, and bits 63:60 are zero.
- R7: `seg_close` during the payload ends the segment. A sample accepted in the same cycle is included. A partial word is padded with zeros before the footer. A close pulse outside a payload is ignored.
- R8: The footer is the packet header with meta type 2. Its segment length field holds the number of payload words sent for the segment, and may be zero.
- R9: When `o_valid` is high and `o_ready` is low, the next cycle keeps `o_valid` high and `o_data` unchanged.
- R10: `smp_ovf` is high in exactly the cycles where `smp_valid` is high and `smp_rdy` is low. Such a sample is discarded.
- R11: `smp_rdy` is high only during a segment's payload phase, and never in a cycle where the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strm_go | input | 1 | Stream start pulse |
| seg_open | input | 1 | Segment opening marker |
| seg_close | input | 1 | Segment closing marker |
| trig_evt | input | 1 | Trigger event pulse |
| ts_whole | input | 64 | Timestamp, integer periods |
| ts_frac | input | 32 | Timestamp, fraction of a period |
| smp_valid | input | 1 | Sample offered |
| smp_data | input | 12 | Sample value |
| smp_rdy | output | 1 | Sample taken this cycle if offered |
| smp_ovf | output | 1 | Offered sample dropped |
| cfg_magic | input | 64 | Magic value starting every header and footer |
| cfg_version | input | 8 | Format version |
| cfg_rate_msps | input | 16 | Input sample rate in MSa/s |
| cfg_dec_exp | input | 8 | Decimation exponent |
| cfg_period_fs | input | 64 | Sample period in femtoseconds |
| o_valid | output | 1 | Output word valid |
| o_ready | input | 1 | Output word accepted |
| o_data | output | 64 | Output word |

## Verification
Two pairs of events can fall in one cycle.

The first pair is a trigger pulse and the acceptance of a segment opening. The bench drives both in the same cycle and expects that cycle's timestamp in the trigger field.

The second pair is the closing marker and the fifth sample of a word. The bench sends ten samples with the close on the last one, while ready is held high. It expects exactly two payload words, no padding word, and a footer length of 2.

A behavioural model assembles every expected header as a wide vector and slices it. Each handshaken word is compared against that model.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int WORD_W = 64;

  typedef struct packed {
    logic [63:0] whole;
    logic [31:0] frac;
  } stamp_t;

  typedef struct packed {
    logic [63:0] magic;
    logic [7:0]  version;
    logic [15:0] rate;
    logic [7:0]  dexp;
    logic [63:0] period;
  } strm_cfg_t;

  typedef enum logic [1:0] {
    MT_STREAM = 2'd0,
    MT_PKT    = 2'd1,
    MT_FOOT   = 2'd2
  } meta_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SHDR, PH_WAIT, PH_PHDR, PH_PAY, PH_FTR
  } phase_t;

  // One 64-bit word of a header or footer; fields sit at fixed bit offsets
  // of the full record, word 0 holding the lowest bits.
  function automatic logic [63:0] meta_word(input int idx, input meta_e mt,
                                            input strm_cfg_t c,
                                            input logic [63:0] seglen,
                                            input stamp_t first,
                                            input stamp_t trig);
    logic [63:0] w;
    w = '0;
    if (idx == 0) begin
      w = c.magic;
    end else if (mt == MT_STREAM) begin
      case (idx)
        1:       w = {c.period[7:0], c.dexp, c.rate, 22'd0, mt, c.version};
        2:       w = {8'd0, c.period[63:8]};
        default: w = '0;
      endcase
    end else begin
      case (idx)
        1:       w = {seglen[31:0], 22'd0, mt, c.version};
        2:       w = {first.whole[31:0], seglen[63:32]};
        3:       w = {first.frac, first.whole[63:32]};
        4:       w = trig.whole;
        5:       w = {32'd0, trig.frac};
        default: w = '0;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/sf_packer.sv
module sf_packer #(
  parameter int SMP_W  = 12,
  parameter int WORD_W = 64,
  localparam int LANES = WORD_W / SMP_W,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              flush,
  input  logic [SMP_W-1:0]  smp,
  output logic [CNT_W-1:0]  fill,
  output logic              full_now,
  output logic [WORD_W-1:0] word_now
);
  localparam int BODY_W = LANES * SMP_W;

  logic [SMP_W-1:0]  lane_q   [LANES];
  logic [SMP_W-1:0]  lane_out [LANES];
  logic [BODY_W-1:0] body;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_out[g] = (CNT_W'(g) < fill) ? lane_q[g] :
                         (take && CNT_W'(g) == fill) ? smp : '0;
    assign body[g*SMP_W +: SMP_W] = lane_out[g];
  end

  assign word_now = {{(WORD_W-BODY_W){1'b0}}, body};
  assign full_now = take && (fill == CNT_W'(LANES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
    end else if (flush) begin
      fill <= '0;
    end else if (take) begin
      lane_q[fill] <= smp;
      fill <= full_now ? '0 : fill + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sf_stamp_latch.sv
module sf_stamp_latch
  import sf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   trig,
  input  logic   open,
  input  stamp_t now,
  output stamp_t first_q,
  output stamp_t seg_trig_q
);
  stamp_t last_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_trig  <= '0;
      first_q    <= '0;
      seg_trig_q <= '0;
    end else begin
      if (trig) last_trig <= now;
      if (open) begin
        first_q    <= now;
        seg_trig_q <= trig ? now : last_trig;
      end
    end
  end
endmodule

// File: rtl/sf_meta_gen.sv
module sf_meta_gen
  import sf_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  input  meta_e            mt,
  input  strm_cfg_t        cfg,
  input  logic [63:0]      seglen,
  input  stamp_t           first,
  input  stamp_t           trig,
  output logic [63:0]      word
);
  assign word = meta_word(int'(idx), mt, cfg, seglen, first, trig);
endmodule

// File: rtl/seg_stream_framer.sv
module seg_stream_framer
  import sf_pkg::*;
#(
  parameter int SMP_W      = 12,
  parameter int SHDR_WORDS = 36,
  parameter int PKT_WORDS  = 18,
  parameter int BLK_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strm_go,
  input  logic             seg_open,
  input  logic             seg_close,
  input  logic             trig_evt,
  input  logic [63:0]      ts_whole,
  input  logic [31:0]      ts_frac,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic             smp_rdy,
  output logic             smp_ovf,
  input  logic [63:0]      cfg_magic,
  input  logic [7:0]       cfg_version,
  input  logic [15:0]      cfg_rate_msps,
  input  logic [7:0]       cfg_dec_exp,
  input  logic [63:0]      cfg_period_fs,
  output logic             o_valid,
  input  logic             o_ready,
  output logic [63:0]      o_data
);
  localparam int LANES = WORD_W / SMP_W;
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int IDX_W = $clog2((SHDR_WORDS > PKT_WORDS) ? SHDR_WORDS : PKT_WORDS);

  phase_t           ph;
  logic [IDX_W-1:0] idx, idx_last;
  logic [BLK_W-1:0] blk;
  logic             end_pend;

  // named internal events
  logic stall, adv, in_pay, take, end_now, ev_open, ev_close;
  logic emit, flush;
  logic [63:0] emit_w, meta_w, pk_word, seglen;
  logic [CNT_W-1:0] pk_fill;
  logic pk_full;
  meta_e mt;
  stamp_t now, first_q, trig_q;
  strm_cfg_t cfg;

  assign now     = '{whole: ts_whole, frac: ts_frac};
  assign cfg     = '{magic: cfg_magic, version: cfg_version, rate: cfg_rate_msps,
                     dexp: cfg_dec_exp, period: cfg_period_fs};
  assign stall   = o_valid && !o_ready;
  assign adv     = !stall;
  assign in_pay  = (ph == PH_PAY);
  assign smp_rdy = in_pay && adv && !end_pend;
  assign smp_ovf = smp_valid && !smp_rdy;
  assign take    = smp_valid && smp_rdy;
  assign end_now = in_pay && (seg_close || end_pend);
  assign ev_open = (ph == PH_WAIT) && seg_open;
  assign idx_last = (ph == PH_SHDR) ? IDX_W'(SHDR_WORDS - 1) : IDX_W'(PKT_WORDS - 1);
  assign seglen  = (ph == PH_FTR) ? {{(64-BLK_W){1'b0}}, blk} : 64'd0;

  always_comb begin
    case (ph)
      PH_SHDR: mt = MT_STREAM;
      PH_FTR:  mt = MT_FOOT;
      default: mt = MT_PKT;
    endcase
  end

  sf_stamp_latch u_stamp (
    .clk(clk), .rst_n(rst_n), .trig(trig_evt), .open(ev_open), .now(now),
    .first_q(first_q), .seg_trig_q(trig_q)
  );

  sf_meta_gen #(.IDX_W(IDX_W)) u_meta (
    .idx(idx), .mt(mt), .cfg(cfg), .seglen(seglen), .first(first_q),
    .trig(trig_q), .word(meta_w)
  );

  sf_packer #(.SMP_W(SMP_W), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .flush(flush), .smp(smp_data),
    .fill(pk_fill), .full_now(pk_full), .word_now(pk_word)
  );

  always_comb begin
    emit     = 1'b0;
    emit_w   = meta_w;
    flush    = 1'b0;
    ev_close = 1'b0;
    case (ph)
      PH_SHDR, PH_PHDR, PH_FTR: emit = 1'b1;
      PH_PAY: begin
        if (pk_full) begin
          emit   = 1'b1;
          emit_w = pk_word;
        end else if (end_now) begin
          ev_close = adv;
          flush    = adv;
          emit     = (pk_fill != '0) || take;
          emit_w   = pk_word;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      idx      <= '0;
      blk      <= '0;
      end_pend <= 1'b0;
      o_valid  <= 1'b0;
      o_data   <= '0;
    end else begin
      if (adv) begin
        o_valid <= emit;
        if (emit) o_data <= emit_w;
      end
      case (ph)
        PH_IDLE: if (strm_go) begin
          ph  <= PH_SHDR;
          idx <= '0;
        end
        PH_WAIT: if (seg_open) begin
          ph  <= PH_PHDR;
          idx <= '0;
        end
        PH_SHDR, PH_PHDR, PH_FTR: if (adv) begin
          if (idx == idx_last) begin
            idx <= '0;
            if (ph == PH_PHDR) begin
              ph  <= PH_PAY;
              blk <= '0;
            end else begin
              ph <= PH_WAIT;
            end
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        PH_PAY: begin
          if (emit && adv) blk <= blk + BLK_W'(1);
          if (ev_close) begin
            ph       <= PH_FTR;
            idx      <= '0;
            end_pend <= 1'b0;
          end else if (seg_close) begin
            end_pend <= 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sf_framer_chk.sv
module sf_framer_chk #(
  parameter int LANES = 5,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             o_valid,
  input logic             o_ready,
  input logic [63:0]      o_data,
  input logic             smp_valid,
  input logic             smp_rdy,
  input logic             smp_ovf,
  input logic             in_pay,
  input logic             ev_open,
  input logic [CNT_W-1:0] pk_fill
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !o_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));

  a_r11_no_take_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |-> !smp_rdy);

  a_r10_flag_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && o_valid && !o_ready) |-> smp_ovf);

  a_r11_rdy_in_payload: assert property (@(posedge clk) disable iff (!rst_n)
    smp_rdy |-> in_pay);

  a_r4_open_outside_payload: assert property (@(posedge clk) disable iff (!rst_n)
    ev_open |-> !in_pay);

  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pk_fill < CNT_W'(LANES));
endmodule

bind seg_stream_framer sf_framer_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data),
  .smp_valid(smp_valid), .smp_rdy(smp_rdy), .smp_ovf(smp_ovf), .in_pay(in_pay),
  .ev_open(ev_open), .pk_fill(pk_fill)
);

// File: tb/sim_seg_stream_framer.sv
module sim_seg_stream_framer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic strm_go = 0, seg_open = 0, seg_close = 0, trig_evt = 0, smp_valid = 0, o_ready = 1;
  logic [11:0] smp_data = '0;
  logic [63:0] ts_whole = '0;
  logic [31:0] ts_frac = '0;
  logic smp_rdy, smp_ovf, o_valid;
  logic [63:0] o_data;

  localparam logic [63:0] MAGIC  = 64'hC0DE_5EED_F00D_1234;
  localparam logic [7:0]  VER    = 8'h03;
  localparam logic [15:0] RATE   = 16'd2500;
  localparam logic [7:0]  DEXP   = 8'd2;
  localparam logic [63:0] PERIOD = 64'h0000_0001_8765_4321;

  seg_stream_framer u0 (
    .clk(clk), .rst_n(rst_n), .strm_go(strm_go), .seg_open(seg_open),
    .seg_close(seg_close), .trig_evt(trig_evt), .ts_whole(ts_whole), .ts_frac(ts_frac),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_rdy(smp_rdy), .smp_ovf(smp_ovf),
    .cfg_magic(MAGIC), .cfg_version(VER), .cfg_rate_msps(RATE), .cfg_dec_exp(DEXP),
    .cfg_period_fs(PERIOD), .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data)
  );

  int checks = 0, fails = 0;
  longint cyc = 0;
  logic [63:0] q[$];
  string qtag[$];
  bit started = 0, inseg = 0, rnd_ready = 0, last_taken = 0, prev_stall = 0;
  logic [63:0] prev_data = '0;
  logic [11:0] part[$];
  int blocks = 0;
  logic [63:0] fw_i = 0, tw_i = 0, lt_i = 0;
  logic [31:0] fw_f = 0, tw_f = 0, lt_f = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void push_meta(input int words, input logic [1:0] mt, input logic [63:0] sl,
                                    input string tag);
    logic [2303:0] v;
    v = '0;
    v[63:0]  = MAGIC;
    v[71:64] = VER;
    v[73:72] = mt;
    if (mt == 2'd0) begin
      v[111:96]  = RATE;
      v[119:112] = DEXP;
      v[183:120] = PERIOD;
    end else begin
      v[159:96]  = sl;
      v[223:160] = fw_i;
      v[255:224] = fw_f;
      v[319:256] = tw_i;
      v[351:320] = tw_f;
    end
    for (int i = 0; i < words; i++) begin
      q.push_back(v[64*i +: 64]);
      qtag.push_back(tag);
    end
  endfunction

  function automatic void push_payload();
    logic [63:0] w;
    w = '0;
    for (int k = 0; k < part.size(); k++) w[12*k +: 12] = part[k];
    q.push_back(w);
    qtag.push_back("R6/R7 payload");
    blocks++;
    part.delete();
  endfunction

  task automatic tick(input bit go = 0, input bit op = 0, input bit cl = 0, input bit trg = 0,
                      input bit sv = 0, input logic [11:0] sd = '0);
    logic [63:0] e;
    string t;
    @(negedge clk);
    cyc++;
    strm_go = go; seg_open = op; seg_close = cl; trig_evt = trg;
    smp_valid = sv; smp_data = sd;
    ts_whole = 64'h0000_5000_0000_0000 + 64'(cyc);
    ts_frac  = 32'(cyc * 32'h0137_F00D);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    o_ready = rnd_ready ? lfsr[0] : 1'b1;
    #1;
    if (rst_n) begin
      if (prev_stall) chk(o_valid && o_data == prev_data, "R9 hold", o_data, prev_data);
      chk(smp_ovf == (sv && !smp_rdy), "R10 overflow flag", 64'(smp_ovf), 64'(sv && !smp_rdy));
      if (o_valid && !o_ready) chk(!smp_rdy, "R11 ready while stalled", 64'(smp_rdy), 0);
      if (smp_rdy) chk(inseg, "R11 ready outside segment", 64'(smp_rdy), 0);
      if (trg) begin lt_i = ts_whole; lt_f = ts_frac; end
      if (go && !started) begin
        started = 1;
        push_meta(36, 2'd0, 0, "R2 stream header");
      end
      if (op && started && !inseg) begin
        inseg = 1; blocks = 0; part.delete();
        fw_i = ts_whole; fw_f = ts_frac; tw_i = lt_i; tw_f = lt_f;
        push_meta(18, 2'd1, 0, "R3/R4/R5 packet header");
      end
      last_taken = sv && smp_rdy;
      if (last_taken) begin
        part.push_back(sd);
        if (part.size() == 5) push_payload();
      end
      if (cl && inseg) begin
        if (part.size() > 0) push_payload();
        push_meta(18, 2'd2, 64'(blocks), "R8 footer");
        inseg = 0;
      end
      if (o_valid && o_ready) begin
        if (q.size() == 0) chk(0, "R2/R7 unexpected word", o_data, 0);
        else begin
          e = q.pop_front();
          t = qtag.pop_front();
          chk(o_data == e, t, o_data, e);
        end
      end
      prev_stall = o_valid && !o_ready;
      prev_data = o_data;
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((q.size() != 0 || o_valid) && n < 3000) begin
      tick();
      n++;
    end
  endtask

  task automatic send(input logic [11:0] v, input bit cl = 0);
    int n = 0;
    do begin
      tick(.sv(1), .sd(v), .cl(cl));
      n++;
    end while (!last_taken && n < 500);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(!o_valid && !smp_rdy && !smp_ovf, "R1 reset state", {o_valid, smp_rdy, smp_ovf}, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk(!o_valid && !smp_rdy, "R1 after reset", {o_valid, smp_rdy}, 0);

    // stream header, repeated start ignored, sample during header dropped
    tick(.go(1));
    tick(); tick(.go(1));
    tick(.sv(1), .sd(12'h111));
    rnd_ready = 1;
    drain();

    // segment A: earlier trigger, random ready, 12 samples, stray open ignored
    tick(.trg(1)); tick();
    tick(.op(1));
    for (int i = 0; i < 12; i++) begin
      send(12'(12'h100 + i * 37));
      if (i == 6) tick(.op(1));
    end
    tick(.cl(1));
    drain();

    // segment B: trigger with open in one cycle, close with tenth sample
    rnd_ready = 0;
    tick(.op(1), .trg(1));
    for (int i = 0; i < 9; i++) send(12'(12'hA00 + i));
    send(12'hABC, 1'b1);
    drain();

    // segment C: stray close while waiting, then an empty segment
    tick(.cl(1));
    tick(.op(1));
    drain();
    tick(.cl(1));
    drain();

    // segment D with trigger in payload; E inherits that trigger
    rnd_ready = 1;
    tick(.op(1));
    for (int i = 0; i < 7; i++) begin
      send(12'(12'hF00 - i * 91));
      if (i == 3) tick(.trg(1));
    end
    tick(.cl(1));
    drain();
    tick(.op(1));
    for (int i = 0; i < 3; i++) send(12'(12'h055 + i));
    tick(.cl(1));
    drain();

    chk(q.size() == 0, "R8 all expected words delivered", 64'(q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule